// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port

An eight-pin general-purpose I/O port attached to a simple synchronous register bus (address, write strobe, write data, combinational read data). Each pin is individually an input or an output. The pin data window spans the low 1 KiB of the address space, and the address itself carries a per-pin select mask, so one bus write can change an arbitrary subset of output pins without a read-modify-write, and one read can sample an arbitrary subset of pins.

Every pin feeds a two-stage synchronizer and then an interrupt detector that can be configured per pin for high level, low level, rising edge, falling edge or either edge. Detected conditions land in a raw status register; a per-pin enable masks that into a masked status, and any set masked bit raises the single interrupt output. Edge-detected status is sticky until software writes a one to the matching bit of the clear register; level-detected status simply tracks the synchronized pin.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset every pin is an input (output enable 0), the output register is 0, every configuration, enable and status register reads 0, and the interrupt output is low.
- R2: A write to an offset below 0x400 updates only the output-register bits whose select bit is set in offset bits [9:2] (pin n uses offset bit n+2); all other output bits keep their value.
- R3: A read of an offset below 0x400 returns, for each pin selected by offset bits [9:2], the output register bit if that pin is an output and the synchronized input otherwise, and 0 for every unselected pin; the pin input reaches the read path after two clock edges.
- R4: Offset 0x400 holds the direction bits: 1 drives the pin from the output register, 0 makes it an input; the output-enable port mirrors this register.
- R5: With the sense bit (offset 0x404) set to 1, a pin is level-detected: its raw status bit one edge later equals the synchronized level when the event bit is 1, or its inverse when the event bit is 0, and a clear write cannot remove it while the level is active.
- R6: With sense 0 and both-edges 0, the event bit (offset 0x40C) selects rising edges (1) or falling edges (0); the edge is found by comparing the synchronized value with its value one cycle earlier and latches the raw status bit.
- R7: With sense 0 and the both-edges bit (offset 0x408) set, either edge latches the raw status bit and the event bit has no effect.
- R8: Writing 1 to a bit of offset 0x41C clears that edge-latched raw status bit; writing 0 leaves it unchanged; the clear offset reads 0.
- R9: Raw status (offset 0x414) shows detected conditions regardless of the enable register (offset 0x410); masked status (offset 0x418) is raw AND enable, and the interrupt output is high exactly when masked status is non-zero.
- R10: If a new qualifying edge is detected in the same cycle as a clear write to that bit, the raw status bit stays set.
- R11: Reads of unmapped offsets return 0, and writes to the raw and masked status offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Byte offset of the access |
| we_i | input | 1 | Write strobe, one write per cycle when high |
| wdata_i | input | 8 | Write data, one bit per pin |
| rdata_o | output | 8 | Read data for the offset on addr_i (combinational) |
| pin_i | input | 8 | Pin input levels, asynchronous |
| pin_o | output | 8 | Output register value |
| pin_oe_o | output | 8 | Per-pin output enable |
| irq_o | output | 1 | Combined interrupt |

## Verification
The two functions that can coincide are edge capture into raw status and a software clear of the same bit. The bench changes a pin and then issues the clear at each of several delays, so that one trial lands the clear on the exact edge where the synchronized edge is detected; its cycle-accurate reference model keeps the bit set in that case and cleared otherwise, and every cycle's outputs and read data are compared against it. Level-detected pins are also cleared while active to confirm the clear cannot win there.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned WIN_MSB = 9;  // top offset bit of the data window

  typedef logic [WORD_W-1:0] word_t;

  localparam word_t W_DIR  = word_t'(10'h100);
  localparam word_t W_SNS  = word_t'(10'h101);
  localparam word_t W_BOTH = word_t'(10'h102);
  localparam word_t W_EVT  = word_t'(10'h103);
  localparam word_t W_EN   = word_t'(10'h104);
  localparam word_t W_RAW  = word_t'(10'h105);
  localparam word_t W_MSK  = word_t'(10'h106);
  localparam word_t W_CLR  = word_t'(10'h107);
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_edge_det.sv
`timescale 1ns/1ps
module gpio_edge_det #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/gpio_irq_bank.sv
`timescale 1ns/1ps
module gpio_irq_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] rise_i,
  input  logic [W-1:0] fall_i,
  input  logic [W-1:0] sense_lvl_i,
  input  logic [W-1:0] both_i,
  input  logic [W-1:0] event_hi_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] raw_o
);
  for (genvar p = 0; p < int'(W); p++) begin : g_pin
    logic raw_bit;
    logic hit;
    logic raw_nxt;

    always_comb begin
      if (both_i[p])        hit = rise_i[p] | fall_i[p];
      else if (event_hi_i[p]) hit = rise_i[p];
      else                  hit = fall_i[p];

      if (sense_lvl_i[p]) raw_nxt = ~(lvl_i[p] ^ event_hi_i[p]);
      else                raw_nxt = hit | (raw_bit & ~clr_i[p]);  // capture beats clear
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) raw_bit <= 1'b0;
      else         raw_bit <= raw_nxt;
    end

    assign raw_o[p] = raw_bit;
  end
endmodule

// File: rtl/gpio_port_irq.sv
`timescale 1ns/1ps
module gpio_port_irq
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  output logic [NUM_PINS-1:0] rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic                irq_o
);
  localparam int unsigned MASK_LSB = 2;
  localparam int unsigned MASK_MSB = MASK_LSB + NUM_PINS - 1;

  word_t               word;
  logic                in_win;
  logic [NUM_PINS-1:0] sel_mask;
  logic [NUM_PINS-1:0] out_q, dir_q, is_q, ibe_q, iev_q, ie_q;
  logic [NUM_PINS-1:0] sync_lvl, rise, fall, raw_st, clr_mask;

  assign word     = addr_i[ADDR_W-1:2];
  assign in_win   = (addr_i[ADDR_W-1:WIN_MSB+1] == '0);
  assign sel_mask = addr_i[MASK_MSB:MASK_LSB];
  assign clr_mask = (we_i && !in_win && word == W_CLR) ? wdata_i : '0;

  gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync_lvl)
  );

  gpio_edge_det #(.W(NUM_PINS)) u_edge (
    .clk_i, .rst_ni, .lvl_i(sync_lvl), .rise_o(rise), .fall_o(fall)
  );

  gpio_irq_bank #(.W(NUM_PINS)) u_irq (
    .clk_i, .rst_ni,
    .lvl_i(sync_lvl), .rise_i(rise), .fall_i(fall),
    .sense_lvl_i(is_q), .both_i(ibe_q), .event_hi_i(iev_q),
    .clr_i(clr_mask), .raw_o(raw_st)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      dir_q <= '0;
      is_q  <= '0;
      ibe_q <= '0;
      iev_q <= '0;
      ie_q  <= '0;
    end else if (we_i) begin
      if (in_win) begin
        out_q <= (out_q & ~sel_mask) | (wdata_i & sel_mask);
      end else begin
        case (word)
          W_DIR:   dir_q <= wdata_i;
          W_SNS:   is_q  <= wdata_i;
          W_BOTH:  ibe_q <= wdata_i;
          W_EVT:   iev_q <= wdata_i;
          W_EN:    ie_q  <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_win) begin
      rdata_o = ((dir_q & out_q) | (~dir_q & sync_lvl)) & sel_mask;
    end else begin
      case (word)
        W_DIR:   rdata_o = dir_q;
        W_SNS:   rdata_o = is_q;
        W_BOTH:  rdata_o = ibe_q;
        W_EVT:   rdata_o = iev_q;
        W_EN:    rdata_o = ie_q;
        W_RAW:   rdata_o = raw_st;
        W_MSK:   rdata_o = raw_st & ie_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign pin_o    = out_q;
  assign pin_oe_o = dir_q;
  assign irq_o    = |(raw_st & ie_q);
endmodule

// File: rtl/gpio_port_irq_chk.sv
`timescale 1ns/1ps
module gpio_port_irq_chk
  import gpio_port_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                we_i,
  input logic [NUM_PINS-1:0] wdata_i,
  input logic [NUM_PINS-1:0] pin_o,
  input logic [NUM_PINS-1:0] pin_oe_o,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] raw_st,
  input logic [NUM_PINS-1:0] ie_q,
  input logic [NUM_PINS-1:0] is_q,
  input logic [NUM_PINS-1:0] iev_q,
  input logic [NUM_PINS-1:0] sync_lvl
);
  logic                data_wr;
  logic [NUM_PINS-1:0] sel;
  logic [NUM_PINS-1:0] clr_now;

  assign data_wr = we_i && (addr_i[ADDR_W-1:WIN_MSB+1] == '0);
  assign sel     = addr_i[NUM_PINS+1:2];
  assign clr_now = (we_i && addr_i[ADDR_W-1:2] == W_CLR) ? wdata_i : '0;

  a_r4_dir_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[ADDR_W-1:2] == W_DIR) |=> pin_oe_o == $past(wdata_i));

  a_r2_masked_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr |=> ((pin_o ^ $past(pin_o)) & ~$past(sel)) == '0);

  a_r2_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_wr |=> $stable(pin_o));

  a_r5_level_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (raw_st & $past(is_q)) == ($past(is_q) & ~($past(sync_lvl) ^ $past(iev_q))));

  a_r8_edge_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (~$past(is_q) & $past(raw_st) & ~raw_st & ~$past(clr_now)) == '0);

  a_r9_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ie_q != '0);
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .pin_o, .pin_oe_o, .irq_o,
  .raw_st, .ie_q, .is_q, .iev_q, .sync_lvl
);

// File: tb/gpio_port_irq_tb.sv
`timescale 1ns/1ps
module gpio_port_irq_tb;
  localparam int N = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [N-1:0] wdata = '0, pins = '0;
  logic [N-1:0] rdata, pout, poe;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_port_irq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pins), .pin_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  // behavioural reference
  logic [N-1:0] m_s1, m_s2, m_prev, m_out, m_dir, m_is, m_ibe, m_iev, m_ie, m_raw;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_s1, m_s2, m_prev, m_out, m_dir, m_is, m_ibe, m_iev, m_ie, m_raw} = '0;
    end else begin
      logic [N-1:0] nraw, clr, mask;
      clr  = (we && addr == 12'h41C) ? wdata : '0;
      mask = addr[9:2];
      for (int i = 0; i < N; i++) begin
        bit r, f, h;
        r = m_s2[i] && !m_prev[i];
        f = !m_s2[i] && m_prev[i];
        if (m_is[i]) nraw[i] = m_iev[i] ? m_s2[i] : !m_s2[i];
        else begin
          h = m_ibe[i] ? (r || f) : (m_iev[i] ? r : f);
          nraw[i] = h || (m_raw[i] && !clr[i]);
        end
      end
      m_raw = nraw;
      if (we) begin
        if (addr < 12'h400) m_out = (m_out & ~mask) | (wdata & mask);
        else case (addr[11:2])
          10'h100: m_dir = wdata;
          10'h101: m_is  = wdata;
          10'h102: m_ibe = wdata;
          10'h103: m_iev = wdata;
          10'h104: m_ie  = wdata;
          default: ;
        endcase
      end
      m_prev = m_s2;
      m_s2   = m_s1;
      m_s1   = pins;
    end
  end

  function automatic logic [N-1:0] exp_rd(logic [11:0] a);
    if (a < 12'h400) return ((m_dir & m_out) | (~m_dir & m_s2)) & a[9:2];
    case (a[11:2])
      10'h100: return m_dir;
      10'h101: return m_is;
      10'h102: return m_ibe;
      10'h103: return m_iev;
      10'h104: return m_ie;
      10'h105: return m_raw;
      10'h106: return m_raw & m_ie;
      default: return '0;
    endcase
  endfunction

  task automatic cmp(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic check(string req);
    cmp(req, "rdata", rdata, exp_rd(addr));
    cmp(req, "irq", irq, (|(m_raw & m_ie)) ? 1 : 0);
    cmp(req, "pin_o", pout, m_out);
    cmp(req, "pin_oe", poe, m_dir);
  endtask

  task automatic cyc(logic [11:0] a, bit w, logic [N-1:0] d, string req);
    addr = a; we = w; wdata = d;
    @(posedge clk); #1;
    check(req);
    we = 1'b0;
  endtask

  task automatic wr(logic [11:0] a, logic [N-1:0] d, string req);
    cyc(a, 1'b1, d, req);
  endtask

  task automatic rd(logic [11:0] a, string req);
    cyc(a, 1'b0, '0, req);
  endtask

  task automatic idle(int n, logic [11:0] a, string req);
    for (int k = 0; k < n; k++) rd(a, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, combinational reads during reset
    for (int k = 0; k < 9; k++) begin
      addr = 12'h3FC + 12'(k * 4); #1; check("R1");
    end
    rst_n = 1'b1;
    idle(2, 12'h400, "R1");

    // R4 / R2: direction and masked output writes
    wr(12'h400, 8'hF0, "R4");
    wr(12'h0F0, 8'hFF, "R2");       // pins 2..5 selected
    rd(12'h3FC, "R2");
    wr(12'h3FC, 8'h00, "R2");
    wr(12'h3FC, 8'hA5, "R2");
    wr(12'h004, 8'h00, "R2");       // only pin 0
    wr(12'h200, 8'h00, "R2");       // only pin 7
    rd(12'h3FC, "R2");

    // R3: mixed read view, latency and mask
    pins = 8'h5A;
    rd(12'h3FC, "R3"); rd(12'h3FC, "R3"); rd(12'h3FC, "R3");
    rd(12'h03C, "R3"); rd(12'h3C0, "R3"); rd(12'h000, "R3");
    wr(12'h400, 8'h00, "R4");
    rd(12'h3FC, "R3");

    // R11: unmapped and read-only offsets
    rd(12'h420, "R11"); rd(12'h500, "R11"); rd(12'hFFC, "R11");
    wr(12'h414, 8'hFF, "R11"); wr(12'h418, 8'hFF, "R11");
    rd(12'h414, "R11"); rd(12'h41C, "R8");

    pins = 8'h00;
    idle(4, 12'h414, "R6");
    wr(12'h41C, 8'hFF, "R8");

    // R5: level detection on pin 0 (high) and pin 6 (low)
    wr(12'h404, 8'h41, "R5");
    wr(12'h40C, 8'h01, "R5");
    wr(12'h410, 8'h41, "R9");
    idle(3, 12'h418, "R5");
    pins[0] = 1'b1;
    idle(4, 12'h414, "R5");
    wr(12'h41C, 8'h41, "R5");       // clear while active
    rd(12'h414, "R5");
    pins[0] = 1'b0; pins[6] = 1'b1;
    idle(4, 12'h418, "R5");
    wr(12'h404, 8'h00, "R5");
    wr(12'h41C, 8'hFF, "R8");
    pins = 8'h00;
    idle(4, 12'h414, "R6");
    wr(12'h41C, 8'hFF, "R8");

    // R6: pin1 rising, pin2 falling
    wr(12'h40C, 8'h02, "R6");
    wr(12'h410, 8'h06, "R9");
    pins[1] = 1'b1; idle(4, 12'h414, "R6");
    pins[1] = 1'b0; idle(4, 12'h414, "R6");
    pins[2] = 1'b1; idle(4, 12'h414, "R6");
    pins[2] = 1'b0; idle(4, 12'h418, "R6");
    // R8: zero write keeps, one write clears
    wr(12'h41C, 8'h00, "R8"); rd(12'h414, "R8");
    wr(12'h41C, 8'h02, "R8"); rd(12'h414, "R8");
    wr(12'h41C, 8'h04, "R8"); rd(12'h418, "R8");

    // R7: both edges on pin 3, event bit set and clear
    wr(12'h408, 8'h08, "R7");
    wr(12'h410, 8'h08, "R9");
    pins[3] = 1'b1; idle(4, 12'h414, "R7");
    wr(12'h41C, 8'h08, "R7");
    pins[3] = 1'b0; idle(4, 12'h414, "R7");
    wr(12'h41C, 8'h08, "R7");
    wr(12'h40C, 8'h08, "R7");
    pins[3] = 1'b1; idle(4, 12'h414, "R7");
    wr(12'h41C, 8'h08, "R7");
    pins[3] = 1'b0; idle(4, 12'h414, "R7");
    wr(12'h41C, 8'h08, "R7");

    // R9: raw visible with enable off
    wr(12'h410, 8'h00, "R9");
    wr(12'h40C, 8'h10, "R9");
    pins[4] = 1'b1; idle(4, 12'h414, "R9");
    rd(12'h418, "R9");
    wr(12'h410, 8'h10, "R9"); rd(12'h418, "R9");
    wr(12'h41C, 8'h10, "R9"); rd(12'h418, "R9");
    pins[4] = 1'b0; idle(3, 12'h414, "R9");

    // R10: clear issued at every offset around the captured edge
    wr(12'h40C, 8'h20, "R10");
    wr(12'h410, 8'h20, "R10");
    for (int d = 0; d < 5; d++) begin
      pins[5] = 1'b1;
      idle(d, 12'h414, "R10");
      wr(12'h41C, 8'h20, "R10");
      idle(4, 12'h414, "R10");
      pins[5] = 1'b0;
      idle(3, 12'h414, "R10");
      wr(12'h41C, 8'h20, "R10");
      rd(12'h414, "R10");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule